// File: doc/BRIEF.md
# Serial Clock-Calendar Register Interface

This block is the target side of a bit-serial interface to a clock-calendar chip. A host selects the block by pulling an active-low enable, then toggles a strobe line while presenting one data bit per strobe. Each transaction is sixteen bits long. The first eight bits form a command byte, sent most significant bit first. The last eight bits are either a byte the host writes or a byte the block returns.

The block holds 32 bytes of battery-backed RAM, a status byte and a fixed control byte. It also returns six BCD time fields that arrive on input pins from a separate timekeeping counter. A power-fail pulse sets a status flag and raises an interrupt line. The interrupt stays raised until the host writes a clear command.

All of the logic runs on one system clock. The strobe and data lines are sampled as synchronous inputs, and a strobe counts on its rising edge.

Top module: `rtc_ser_if`

## Requirements
- R1: A strobe is a low-to-high change of `ser_clk` seen on a `clk` edge while `ser_ce_n` is low. Strobe changes while `ser_ce_n` is high have no effect.
- R2: Strobes 1 to 8 of a transaction shift the command in, MSB first. Command bit 7 equal to 1 marks a write and 0 marks a read.
- R3: The read byte is captured on the 8th strobe. On strobe 9+k (k = 0..7), `ser_dout` takes bit 7−k of that byte. `ser_dout` is 0 while `ser_ce_n` is high.
- R4: Read codes 0x00 to 0x1F return RAM byte number (code).
- R5: Read codes 0x20, 0x21, 0x22, 0x24, 0x25 and 0x26 return the second, minute, hour, day, month and year inputs. Every other code from 0x20 to 0x2F returns 0x00.
- R6: Read code 0x30 returns the status byte, which is 0x98 after reset. Read code 0x31 returns the control byte (parameter, default 0x00). Read codes 0x32 to 0x7F return 0x00.
- R7: On strobes 9 to 16 of a write, the data byte is shifted in MSB first. Write codes 0x80 to 0x9F store that byte into RAM byte number (code − 0x80) on the 16th strobe. A write that is abandoned before its 16th strobe stores nothing.
- R8: Write code 0xB1 with data bit 2 set clears status bits 4 and 3 and drops `pwr_irq`. With data bit 2 clear, the write changes nothing.
- R9: Write codes other than 0x80 to 0x9F and 0xB1 change no RAM byte and no status bit.
- R10: Raising `ser_ce_n` returns the block to bit 0. Strobes after the 16th are ignored until `ser_ce_n` has been high.
- R11: A `pwr_fail` pulse sets status bit 4 and raises `pwr_irq` one cycle later. `pwr_irq` then stays high until an R8 clear. If a pulse and a clear arrive in the same cycle, the pulse wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_ce_n | input | 1 | Active-low transaction enable |
| ser_clk | input | 1 | Host bit strobe |
| ser_din | input | 1 | Serial data from host |
| ser_dout | output | 1 | Serial data to host |
| pwr_fail | input | 1 | Power-fail event pulse |
| tm_sec | input | 8 | BCD seconds |
| tm_min | input | 8 | BCD minutes |
| tm_hour | input | 8 | BCD hours |
| tm_mday | input | 8 | BCD day of month |
| tm_mon | input | 8 | BCD month, 1 to 12 |
| tm_year | input | 8 | BCD two-digit year |
| pwr_irq | output | 1 | Power-event interrupt |

## Verification
Each strobe takes effect on the first `clk` edge that sees `ser_clk` high. The bench raises the strobe on a falling edge and reads `ser_dout` at the next falling edge, half a period after the register has updated. A RAM write lands on the 16th strobe, so the bench only reads it back in a later transaction. `pwr_irq` follows `pwr_fail` by one edge, and a status clear follows the 16th strobe of the 0xB1 write by one edge. The bench samples both on the falling edge after the transaction ends.

// File: rtl/rtc_ser_pkg.sv
package rtc_ser_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  localparam byte_t CODE_SEC    = 8'h20;
  localparam byte_t CODE_MIN    = 8'h21;
  localparam byte_t CODE_HOUR   = 8'h22;
  localparam byte_t CODE_MDAY   = 8'h24;
  localparam byte_t CODE_MON    = 8'h25;
  localparam byte_t CODE_YEAR   = 8'h26;
  localparam byte_t CODE_STAT   = 8'h30;
  localparam byte_t CODE_CTRL   = 8'h31;
  localparam byte_t CODE_STCLR  = 8'hB1;
  localparam byte_t STAT_CLRMSK = 8'h18;
  localparam int unsigned STAT_PWR_BIT  = 4;
  localparam int unsigned CLR_TRIG_BIT  = 2;

  function automatic logic is_write(input byte_t code);
    return code[BYTE_W-1];
  endfunction
endpackage

// File: rtl/rtc_ser_shift.sv
module rtc_ser_shift
  import rtc_ser_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ce_n,
  input  logic  sclk,
  input  logic  din,
  output logic  dout,
  output byte_t rd_addr,
  input  byte_t rd_data,
  output logic  wr_en,
  output byte_t wr_code,
  output byte_t wr_data
);
  localparam int unsigned PH_W   = $clog2(2*BYTE_W) + 1;
  localparam logic [PH_W-1:0] PH_CMD_LAST = PH_W'(BYTE_W - 1);
  localparam logic [PH_W-1:0] PH_DATA0    = PH_W'(BYTE_W);
  localparam logic [PH_W-1:0] PH_LAST     = PH_W'(2*BYTE_W - 1);
  localparam logic [PH_W-1:0] PH_DONE     = PH_W'(2*BYTE_W);

  logic [PH_W-1:0] phase_q, phase_d;
  byte_t cmd_q, cmd_d, val_q, val_d, ret_q, ret_d;
  logic  sclk_q, dout_q, dout_d;
  logic  strobe, active;
  byte_t cmd_shift, val_shift;

  assign strobe    = sclk && !sclk_q && !ce_n;
  assign active    = strobe && (phase_q < PH_DONE);
  assign cmd_shift = {cmd_q[BYTE_W-2:0], din};
  assign val_shift = {val_q[BYTE_W-2:0], din};
  assign rd_addr   = cmd_shift;

  always_comb begin
    phase_d = phase_q;
    cmd_d   = cmd_q;
    val_d   = val_q;
    ret_d   = ret_q;
    dout_d  = dout_q;
    wr_en   = 1'b0;
    if (ce_n) begin
      phase_d = '0;
      dout_d  = 1'b0;
    end else if (active) begin
      phase_d = phase_q + 1'b1;
      if (phase_q < PH_DATA0) begin
        cmd_d = cmd_shift;
        if (phase_q == PH_CMD_LAST && !is_write(cmd_shift))
          ret_d = rd_data;
      end else if (is_write(cmd_q)) begin
        val_d = val_shift;
        wr_en = (phase_q == PH_LAST);
      end else begin
        dout_d = ret_q[~phase_q[2:0]];
      end
    end
  end

  assign wr_code = cmd_q;
  assign wr_data = val_shift;
  assign dout    = dout_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      cmd_q   <= '0;
      val_q   <= '0;
      ret_q   <= '0;
      dout_q  <= 1'b0;
      sclk_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cmd_q   <= cmd_d;
      val_q   <= val_d;
      ret_q   <= ret_d;
      dout_q  <= dout_d;
      sclk_q  <= sclk;
    end
  end

  p_phase_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q <= PH_DONE);
  p_ce_rewind_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> (phase_q == '0 && !dout));
  p_phase_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && phase_q < PH_DONE) |=> phase_q == $past(phase_q) + 1'b1);
  p_hold_no_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !strobe) |=> $stable(phase_q));
endmodule

// File: rtl/rtc_ser_regs.sv
module rtc_ser_regs
  import rtc_ser_pkg::*;
#(
  parameter int unsigned RAM_WORDS  = 32,
  parameter byte_t       STAT_RESET = 8'h98,
  parameter byte_t       CTRL_VALUE = 8'h00
)(
  input  logic  clk,
  input  logic  rst_n,
  input  byte_t rd_addr,
  output byte_t rd_data,
  input  logic  wr_en,
  input  byte_t wr_code,
  input  byte_t wr_data,
  input  logic  pwr_fail,
  input  byte_t tm_sec,
  input  byte_t tm_min,
  input  byte_t tm_hour,
  input  byte_t tm_mday,
  input  byte_t tm_mon,
  input  byte_t tm_year,
  output logic  pwr_irq
);
  localparam int unsigned AW = $clog2(RAM_WORDS);

  byte_t ram_q [RAM_WORDS];
  byte_t stat_q, stat_d;
  logic  irq_q, irq_d, clr_hit, ram_wr_hit;
  byte_t time_sel;

  assign ram_wr_hit = wr_en && is_write(wr_code) && (wr_code[BYTE_W-2:AW] == '0);
  assign clr_hit    = wr_en && (wr_code == CODE_STCLR) && wr_data[CLR_TRIG_BIT];

  for (genvar i = 0; i < RAM_WORDS; i++) begin : g_ram
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ram_q[i] <= '0;
      else if (ram_wr_hit && wr_code[AW-1:0] == AW'(i))
        ram_q[i] <= wr_data;
    end
  end

  always_comb begin
    stat_d = stat_q;
    irq_d  = irq_q;
    if (clr_hit) begin
      stat_d = stat_q & ~STAT_CLRMSK;
      irq_d  = 1'b0;
    end
    if (pwr_fail) begin
      stat_d[STAT_PWR_BIT] = 1'b1;
      irq_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= STAT_RESET;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      irq_q  <= irq_d;
    end
  end

  always_comb begin
    case (rd_addr)
      CODE_SEC:  time_sel = tm_sec;
      CODE_MIN:  time_sel = tm_min;
      CODE_HOUR: time_sel = tm_hour;
      CODE_MDAY: time_sel = tm_mday;
      CODE_MON:  time_sel = tm_mon;
      CODE_YEAR: time_sel = tm_year;
      default:   time_sel = '0;
    endcase
  end

  always_comb begin
    if (rd_addr[BYTE_W-1:AW] == '0)
      rd_data = ram_q[rd_addr[AW-1:0]];
    else if (rd_addr[BYTE_W-1:4] == 4'h2)
      rd_data = time_sel;
    else if (rd_addr == CODE_STAT)
      rd_data = stat_q;
    else if (rd_addr == CODE_CTRL)
      rd_data = CTRL_VALUE;
    else
      rd_data = '0;
  end

  assign pwr_irq = irq_q;

  p_irq_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> (pwr_irq && stat_q[STAT_PWR_BIT]));
  p_irq_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_irq && !clr_hit) |=> pwr_irq);
  p_irq_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_irq |-> stat_q[STAT_PWR_BIT]);
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && !pwr_fail) |=> (!pwr_irq && (stat_q & STAT_CLRMSK) == '0));
endmodule

// File: rtl/rtc_ser_if.sv
module rtc_ser_if
  import rtc_ser_pkg::*;
#(
  parameter int unsigned RAM_WORDS  = 32,
  parameter logic [7:0]  STAT_RESET = 8'h98,
  parameter logic [7:0]  CTRL_VALUE = 8'h00
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ser_ce_n,
  input  logic       ser_clk,
  input  logic       ser_din,
  output logic       ser_dout,
  input  logic       pwr_fail,
  input  logic [7:0] tm_sec,
  input  logic [7:0] tm_min,
  input  logic [7:0] tm_hour,
  input  logic [7:0] tm_mday,
  input  logic [7:0] tm_mon,
  input  logic [7:0] tm_year,
  output logic       pwr_irq
);
  byte_t rd_addr, rd_data, wr_code, wr_data;
  logic  wr_en;

  rtc_ser_shift u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_n    (ser_ce_n),
    .sclk    (ser_clk),
    .din     (ser_din),
    .dout    (ser_dout),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .wr_en   (wr_en),
    .wr_code (wr_code),
    .wr_data (wr_data)
  );

  rtc_ser_regs #(
    .RAM_WORDS  (RAM_WORDS),
    .STAT_RESET (STAT_RESET),
    .CTRL_VALUE (CTRL_VALUE)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .wr_en    (wr_en),
    .wr_code  (wr_code),
    .wr_data  (wr_data),
    .pwr_fail (pwr_fail),
    .tm_sec   (tm_sec),
    .tm_min   (tm_min),
    .tm_hour  (tm_hour),
    .tm_mday  (tm_mday),
    .tm_mon   (tm_mon),
    .tm_year  (tm_year),
    .pwr_irq  (pwr_irq)
  );
endmodule

// File: tb/tb_rtc_ser_if.sv
module tb_rtc_ser_if;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_ce_n = 1'b1, ser_clk = 1'b0, ser_din = 1'b0, pwr_fail = 1'b0;
  logic ser_dout, pwr_irq;
  logic [7:0] tm_sec = 8'h59, tm_min = 8'h07, tm_hour = 8'h23;
  logic [7:0] tm_mday = 8'h31, tm_mon = 8'h12, tm_year = 8'h24;
  int checks = 0, errors = 0;
  logic [7:0] rv;
  logic [7:0] shadow [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_ser_if dut (
    .clk(clk), .rst_n(rst_n), .ser_ce_n(ser_ce_n), .ser_clk(ser_clk),
    .ser_din(ser_din), .ser_dout(ser_dout), .pwr_fail(pwr_fail),
    .tm_sec(tm_sec), .tm_min(tm_min), .tm_hour(tm_hour), .tm_mday(tm_mday),
    .tm_mon(tm_mon), .tm_year(tm_year), .pwr_irq(pwr_irq)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic strobe(input logic b, output logic d);
    @(negedge clk);
    ser_din = b;
    ser_clk = 1'b1;
    @(negedge clk);
    d = ser_dout;
    ser_clk = 1'b0;
  endtask

  task automatic begin_xfer();
    @(negedge clk);
    ser_ce_n = 1'b0;
  endtask

  task automatic end_xfer();
    @(negedge clk);
    ser_ce_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] v, output logic [7:0] r);
    logic d;
    for (int i = 7; i >= 0; i--) begin
      strobe(v[i], d);
      r[i] = d;
    end
  endtask

  task automatic xfer(input logic [7:0] cmd, input logic [7:0] wv, output logic [7:0] r);
    logic [7:0] junk;
    begin_xfer();
    send_bits(cmd, junk);
    send_bits(wv, r);
    end_xfer();
  endtask

  task automatic pulse_pwr();
    @(negedge clk);
    pwr_fail = 1'b1;
    @(negedge clk);
    pwr_fail = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] junk;
    logic d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R3 dout idle after reset", {7'd0, ser_dout}, 8'h00);
    chk("R11 irq low after reset", {7'd0, pwr_irq}, 8'h00);
    xfer(8'h30, 8'h00, rv); chk("R6 status reset", rv, 8'h98);
    xfer(8'h31, 8'h00, rv); chk("R6 control", rv, 8'h00);
    for (int a = 8'h32; a < 8'h80; a += 13) begin
      xfer(8'(a), 8'h00, rv); chk("R6 unmapped read", rv, 8'h00);
    end

    // R7 R4: fill RAM sweep then read back
    for (int i = 0; i < 32; i++) begin
      shadow[i] = 8'((i * 37 + 5) % 256);
      xfer(8'(8'h80 + i), shadow[i], junk);
    end
    for (int i = 0; i < 32; i++) begin
      xfer(8'(i), 8'h00, rv); chk("R4 R7 ram readback", rv, shadow[i]);
    end

    // R5: time field sweep
    for (int c = 8'h20; c <= 8'h2F; c++) begin
      logic [7:0] e;
      case (c)
        8'h20: e = tm_sec;  8'h21: e = tm_min;  8'h22: e = tm_hour;
        8'h24: e = tm_mday; 8'h25: e = tm_mon;  8'h26: e = tm_year;
        default: e = 8'h00;
      endcase
      xfer(8'(c), 8'h00, rv); chk("R5 time field", rv, e);
    end
    tm_sec = 8'h00; tm_year = 8'h99;
    xfer(8'h20, 8'h00, rv); chk("R5 seconds follow input", rv, 8'h00);
    xfer(8'h26, 8'h00, rv); chk("R5 year follow input", rv, 8'h99);

    // R3: per-bit timing of the read stream
    begin_xfer();
    send_bits(8'h03, junk);
    for (int k = 0; k < 8; k++) begin
      strobe(1'b0, d);
      chk("R3 bit after data strobe", {7'd0, d}, {7'd0, shadow[3][7-k]});
    end
    // R10: extra strobes ignored, dout holds last bit
    for (int k = 0; k < 4; k++) begin
      strobe(~shadow[3][0], d);
      chk("R10 extra strobe ignored", {7'd0, d}, {7'd0, shadow[3][0]});
    end
    end_xfer();
    chk("R3 dout low with enable high", {7'd0, ser_dout}, 8'h00);

    // R9: unmapped writes change nothing
    xfer(8'hA5, 8'h11, junk);
    xfer(8'hC0, 8'h22, junk);
    xfer(8'hB0, 8'hFF, junk);
    xfer(8'h05, 8'h00, rv); chk("R9 ram untouched", rv, shadow[5]);
    xfer(8'h00, 8'h00, rv); chk("R9 ram untouched", rv, shadow[0]);
    xfer(8'h30, 8'h00, rv); chk("R9 status untouched", rv, 8'h98);

    // R7 R10: abandoned write commits nothing, then recovery
    begin_xfer();
    send_bits(8'h87, junk);
    for (int k = 0; k < 5; k++) strobe(1'b1, d);
    end_xfer();
    xfer(8'h07, 8'h00, rv); chk("R7 abandoned write", rv, shadow[7]);
    begin_xfer();
    for (int k = 0; k < 3; k++) strobe(1'b1, d);
    end_xfer();
    xfer(8'h09, 8'h00, rv); chk("R10 restart after abort", rv, shadow[9]);

    // R1: strobe activity while disabled
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); ser_din = 1'b1; ser_clk = 1'b1;
      @(negedge clk); ser_clk = 1'b0;
    end
    xfer(8'h0A, 8'h00, rv); chk("R1 disabled strobes ignored", rv, shadow[10]);
    // R1: held-high strobe counts once
    begin_xfer();
    send_bits(8'h8C, junk);
    @(negedge clk); ser_din = 1'b1; ser_clk = 1'b1;
    repeat (4) @(negedge clk);
    ser_clk = 1'b0;
    for (int k = 0; k < 7; k++) strobe(1'b0, d);
    end_xfer();
    xfer(8'h0C, 8'h00, rv); chk("R1 R2 one strobe per rise", rv, 8'h80);

    // R11 R8: power event and clear
    pulse_pwr();
    @(negedge clk);
    chk("R11 irq raised", {7'd0, pwr_irq}, 8'h01);
    xfer(8'h30, 8'h00, rv); chk("R11 status bit4", rv, 8'h98);
    xfer(8'hB1, 8'hFB, junk);
    chk("R8 no clear without bit2", {7'd0, pwr_irq}, 8'h01);
    xfer(8'h30, 8'h00, rv); chk("R8 status kept", rv, 8'h98);
    xfer(8'hB1, 8'h04, junk);
    chk("R8 irq cleared", {7'd0, pwr_irq}, 8'h00);
    xfer(8'h30, 8'h00, rv); chk("R8 status cleared", rv, 8'h80);
    pulse_pwr();
    @(negedge clk);
    chk("R11 irq re-raised", {7'd0, pwr_irq}, 8'h01);
    xfer(8'h30, 8'h00, rv); chk("R11 bit4 only", rv, 8'h90);
    repeat (20) @(negedge clk);
    chk("R11 irq held", {7'd0, pwr_irq}, 8'h01);

    // R11: pulse coinciding with clear commit
    begin_xfer();
    send_bits(8'hB1, junk);
    for (int k = 7; k >= 1; k--) strobe(k == 2, d);
    @(negedge clk);
    ser_din = 1'b0; ser_clk = 1'b1; pwr_fail = 1'b1;
    @(negedge clk);
    ser_clk = 1'b0; pwr_fail = 1'b0;
    end_xfer();
    chk("R11 pulse wins over clear", {7'd0, pwr_irq}, 8'h01);
    xfer(8'h30, 8'h00, rv); chk("R11 status after tie", rv, 8'h90);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule